// File: doc/BRIEF.md
# Banded Cholesky Factoriser with Forward Substitution

The block factors a symmetric positive-definite band matrix, one row at a time, into a lower-triangular factor L with A = L·Lᵀ. In the same pass it solves L·y = b by forward substitution. Off-diagonal entries further than W columns from the diagonal are zero and stay zero in L, so the engine keeps only the W most recent rows of L and the W most recent values of y. It never stores the whole matrix.

A producer hands over one row of A at a time: the W+1 entries from column j−W up to the diagonal, plus b_j. The engine then emits the band entries of row j of L in ascending column order, followed by y_j. Each output word carries its row and column index, so a later backward-substitution stage can collect L and y in memory. The arithmetic is signed fixed point. Each division uses a bit-serial divider and the square root uses a bit-serial root extractor. If the value under a square root is not positive, the current matrix is abandoned.

Top module: `band_chol_fwd`

## Requirements
- R1: After reset `in_ready` is 1 and both `out_valid` and `err_npd` are 0.
- R2: A row is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 until the row's y value has been emitted, or until an error ends the row.
- R3: Values are DW-bit two's complement with FRAC fraction bits. In a dot product the full-precision products are summed and the sum is shifted arithmetically right by FRAC once. A quotient is (num·2^FRAC)/den truncated toward zero. A root is floor(sqrt(d·2^FRAC)).
- R4: An off-diagonal entry is L[j][c] = (A[j][c] − Σ_k L[j][k]·L[c][k]) / L[c][c], where k runs over the band columns below c.
- R5: A diagonal entry is L[j][j] = sqrt(A[j][j] − Σ_k L[j][k]²), where k runs over the band columns below j.
- R6: After L[j][j], the engine emits y_j = (b_j − Σ_k L[j][k]·y_k) / L[j][j] with `out_is_y`=1 and `out_col`=`out_row`=j.
- R7: Output words appear in row order. Within a row they appear in ascending column order from max(0, j−W) to j, followed by y_j. A row therefore yields min(j,W)+1 factor entries, all inside the band.
- R8: `out_last` is 1 only on the y word of a row that was accepted with `in_last`=1. The next row accepted after that is row 0 of a new matrix.
- R9: A value under the square root that is ≤ 0 raises `err_npd` for one cycle. Neither the diagonal nor y is emitted for that row, and the next row accepted is row 0 of a new matrix.
- R10: Slot k of `in_a` (bits k·DW and up) holds A[j][j−W+k], and slot W holds the diagonal. Slots whose column would be negative are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A row of A and b_j is offered |
| in_ready | output | 1 | Engine can accept a row |
| in_a | input | DW*(W+1) | Band entries of row j of A, slot W is the diagonal |
| in_b | input | DW | Right-hand-side value b_j |
| in_last | input | 1 | This row is the final row of the matrix |
| out_valid | output | 1 | One-cycle strobe for an output word |
| out_row | output | IW | Row index of the word |
| out_col | output | IW | Column index of the word |
| out_val | output | DW | Value of L entry or of y |
| out_is_y | output | 1 | Word carries y_j rather than an L entry |
| out_last | output | 1 | Word is y of the final row |
| err_npd | output | 1 | One-cycle strobe: matrix is not positive definite |

## Verification
On every cycle the assertions check the following:
- every emitted factor column lies within W of its row and never above it;
- emitted diagonal values are positive;
- the last flag only rides on a y word;
- an error strobe never coincides with an output word;
- the engine re-opens for input after an error;
- the input handshake closes once a row is taken.

The numerical content can only be shown by the bench's scenarios, which compare every emitted value against a bit-exact fixed-point model. These checks cover the ordering of words, the restart at row 0 after a final row or an error, and the fact that out-of-band input slots are ignored.

// File: rtl/band_chol_fwd.sv
module band_chol_fwd #(
  parameter int W    = 2,
  parameter int DW   = 24,
  parameter int FRAC = 10,
  parameter int IW   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [DW*(W+1)-1:0]   in_a,
  input  logic [DW-1:0]         in_b,
  input  logic                  in_last,
  output logic                  out_valid,
  output logic [IW-1:0]         out_row,
  output logic [IW-1:0]         out_col,
  output logic [DW-1:0]         out_val,
  output logic                  out_is_y,
  output logic                  out_last,
  output logic                  err_npd
);
  localparam int NB = DW + FRAC;
  localparam int RW = NB / 2 + 1;
  localparam int PW = 2 * DW;
  localparam int SW = PW + $clog2(W + 1) + 1;
  localparam int TW = $clog2(W + 1);
  localparam int CW = $clog2(NB + 1);
  localparam int QW = 2 * RW;

  typedef enum logic [2:0] {S_IDLE, S_ENT, S_DIV, S_SQRT, S_Y} state_t;
  state_t state;

  logic signed [DW-1:0] a_r [0:W];
  logic signed [DW-1:0] cur [0:W];
  logic signed [DW-1:0] ct  [0:W-1][0:W];
  logic signed [DW-1:0] yv  [0:W-1];
  logic signed [DW-1:0] b_r;
  logic                 last_r;
  logic [IW-1:0]        row;
  logic [TW-1:0]        t;

  logic [NB-1:0]        dq;
  logic [DW-1:0]        drem, dden;
  logic                 dneg, dmode_y;
  logic [CW-1:0]        cnt;
  logic [NB-1:0]        srad;
  logic [RW-1:0]        sroot;
  logic [CW-1:0]        scnt;

  int                   ti, tsel;
  logic signed [SW-1:0] dot, dsh, numw;
  logic signed [DW-1:0] num_c, den_c, q;
  logic [DW-1:0]        mag;
  logic [DW:0]          rem_sh;
  logic [NB-1:0]        dq_n;
  logic [DW-1:0]        drem_n;
  logic [RW-1:0]        trial, root_n;
  logic [QW-1:0]        sq;

  assign in_ready = (state == S_IDLE);
  assign ti   = int'(t);
  assign tsel = (ti < W) ? ti : 0;

  // dot product over the band: one multiplier per cached operand pair
  always_comb begin
    logic signed [PW-1:0] p;
    dot = '0;
    for (int m = 0; m < W; m++) begin
      p = '0;
      if (state == S_Y)      p = cur[m] * yv[m];
      else if (ti == W)      p = cur[m] * cur[m];
      else if (m < ti)       p = cur[m] * ct[tsel][m + W - tsel];
      dot = dot + SW'(p);
    end
  end

  assign dsh   = dot >>> FRAC;
  assign numw  = SW'((state == S_Y) ? b_r : a_r[ti]) - dsh;
  assign num_c = numw[DW-1:0];
  assign den_c = (state == S_Y) ? cur[W] : ct[tsel][W];
  assign mag   = num_c[DW-1] ? DW'(-num_c) : DW'(num_c);

  assign rem_sh = {drem, dq[NB-1]};
  always_comb begin
    if (rem_sh >= {1'b0, dden}) begin
      drem_n = DW'(rem_sh - {1'b0, dden});
      dq_n   = {dq[NB-2:0], 1'b1};
    end else begin
      drem_n = rem_sh[DW-1:0];
      dq_n   = {dq[NB-2:0], 1'b0};
    end
  end
  assign q = dneg ? -$signed(dq_n[DW-1:0]) : $signed(dq_n[DW-1:0]);

  assign trial  = sroot | (RW'(1) << scnt);
  assign sq     = {{RW{1'b0}}, trial} * {{RW{1'b0}}, trial};
  assign root_n = (sq <= {{(QW-NB){1'b0}}, srad}) ? trial : sroot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      for (int k = 0; k <= W; k++) begin a_r[k] <= '0; cur[k] <= '0; end
      for (int r = 0; r < W; r++) begin
        yv[r] <= '0;
        for (int k = 0; k <= W; k++) ct[r][k] <= '0;
      end
      b_r <= '0; last_r <= 1'b0; row <= '0; t <= '0;
      dq <= '0; drem <= '0; dden <= '0; dneg <= 1'b0; dmode_y <= 1'b0; cnt <= '0;
      srad <= '0; sroot <= '0; scnt <= '0;
      out_valid <= 1'b0; out_row <= '0; out_col <= '0; out_val <= '0;
      out_is_y <= 1'b0; out_last <= 1'b0; err_npd <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      err_npd   <= 1'b0;
      case (state)
        S_IDLE: if (in_valid) begin
          for (int k = 0; k <= W; k++) begin
            a_r[k] <= in_a[k*DW +: DW];
            cur[k] <= '0;
          end
          b_r    <= in_b;
          last_r <= in_last;
          if (int'(row) < W) t <= TW'(W - int'(row));
          else t <= '0;
          state <= S_ENT;
        end
        S_ENT: if (ti < W) begin
          dq <= {mag, {FRAC{1'b0}}}; drem <= '0; dden <= den_c;
          dneg <= num_c[DW-1]; dmode_y <= 1'b0; cnt <= '0;
          state <= S_DIV;
        end else if (num_c <= 0) begin
          err_npd <= 1'b1;
          row <= '0;
          for (int r = 0; r < W; r++) begin
            yv[r] <= '0;
            for (int k = 0; k <= W; k++) ct[r][k] <= '0;
          end
          state <= S_IDLE;
        end else begin
          srad <= {num_c, {FRAC{1'b0}}}; sroot <= '0; scnt <= CW'(RW - 1);
          state <= S_SQRT;
        end
        S_SQRT: begin
          sroot <= root_n;
          scnt  <= scnt - 1'b1;
          if (scnt == '0) begin
            cur[W]    <= DW'(root_n);
            out_valid <= 1'b1; out_is_y <= 1'b0;
            out_row   <= row;  out_col  <= row; out_val <= DW'(root_n);
            state     <= S_Y;
          end
        end
        S_Y: begin
          dq <= {mag, {FRAC{1'b0}}}; drem <= '0; dden <= den_c;
          dneg <= num_c[DW-1]; dmode_y <= 1'b1; cnt <= '0;
          state <= S_DIV;
        end
        S_DIV: begin
          dq   <= dq_n;
          drem <= drem_n;
          cnt  <= cnt + 1'b1;
          if (cnt == CW'(NB - 1)) begin
            out_valid <= 1'b1;
            out_val   <= q;
            out_row   <= row;
            if (!dmode_y) begin
              cur[ti]  <= q;
              out_is_y <= 1'b0;
              out_col  <= row - IW'(W) + IW'(t);
              t        <= t + 1'b1;
              state    <= S_ENT;
            end else begin
              out_is_y <= 1'b1;
              out_col  <= row;
              out_last <= last_r;
              if (last_r) begin
                row <= '0;
                for (int r = 0; r < W; r++) begin
                  yv[r] <= '0;
                  for (int k = 0; k <= W; k++) ct[r][k] <= '0;
                end
              end else begin
                row <= row + 1'b1;
                for (int r = 0; r < W - 1; r++) begin
                  ct[r] <= ct[r+1];
                  yv[r] <= yv[r+1];
                end
                ct[W-1] <= cur;
                yv[W-1] <= q;
              end
              state <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2
  handshake_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  // R7
  band_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_y) |-> (out_col <= out_row && (out_row - out_col) <= IW'(W)));
  // R5
  diag_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_y && out_row == out_col) |-> $signed(out_val) > 0);
  // R8
  last_on_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && out_is_y));
  // R9
  err_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, err_npd}));
  // R9
  err_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_npd |-> in_ready);
endmodule

// File: tb/sim_band_chol_fwd.sv
`timescale 1ns/1ps
module sim_band_chol_fwd;
  localparam int W = 2, DW = 24, FRAC = 10, IW = 8, NMAX = 8, EMAX = 64;
  localparam longint ONE = 64'sd1 << FRAC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [DW*(W+1)-1:0] in_a = '0;
  logic [DW-1:0] in_b = '0;
  logic in_ready, out_valid, out_is_y, out_last, err_npd;
  logic [IW-1:0] out_row, out_col;
  logic [DW-1:0] out_val;

  band_chol_fwd #(.W(W), .DW(DW), .FRAC(FRAC), .IW(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_last(in_last), .out_valid(out_valid),
    .out_row(out_row), .out_col(out_col), .out_val(out_val),
    .out_is_y(out_is_y), .out_last(out_last), .err_npd(err_npd));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  longint A [NMAX][NMAX];
  longint bv [NMAX];
  longint Lm [NMAX][NMAX];
  longint ym [NMAX];
  int et [EMAX]; int er [EMAX]; int ec [EMAX]; longint ev [EMAX]; bit el [EMAX];
  int en = 0, eidx = 0;
  string scen = "";

  function automatic longint wrap(longint v);
    longint m;
    m = (64'sd1 << DW);
    v = v & (m - 1);
    if (v >= (m >>> 1)) v = v - m;
    return v;
  endfunction

  function automatic longint isq(longint x);
    longint r;
    r = longint'($floor($sqrt(real'(x))));
    while (r * r > x) r--;
    while ((r + 1) * (r + 1) <= x) r++;
    return r;
  endfunction

  function automatic void push(int ty, int r, int c, longint v, bit l);
    et[en] = ty; er[en] = r; ec[en] = c; ev[en] = v; el[en] = l; en++;
  endfunction

  // R3 R4 R5 R6: fixed-point model of the factorisation and substitution
  function automatic void build(int n);
    longint s, num, d;
    int lo;
    en = 0; eidx = 0;
    for (int j = 0; j < n; j++) begin
      lo = (j - W < 0) ? 0 : j - W;
      for (int c = lo; c < j; c++) begin
        s = 0;
        for (int k = lo; k < c; k++) s += Lm[j][k] * Lm[c][k];
        num = wrap(A[j][c] - (s >>> FRAC));
        Lm[j][c] = wrap((num * ONE) / Lm[c][c]);
        push(0, j, c, Lm[j][c], 1'b0);
      end
      s = 0;
      for (int k = lo; k < j; k++) s += Lm[j][k] * Lm[j][k];
      d = wrap(A[j][j] - (s >>> FRAC));
      if (d <= 0) begin push(2, j, j, 0, 1'b0); return; end
      Lm[j][j] = isq(d * ONE);
      push(0, j, j, Lm[j][j], 1'b0);
      s = 0;
      for (int k = lo; k < j; k++) s += Lm[j][k] * ym[k];
      num = wrap(bv[j] - (s >>> FRAC));
      ym[j] = wrap((num * ONE) / Lm[j][j]);
      push(1, j, j, ym[j], j == n - 1);
    end
  endfunction

  function automatic string tag(int ty, int r, int c);
    if (ty == 2) return "R9";
    if (ty == 1) return "R6 R8";
    if (r == c) return "R5 R3";
    return "R4 R7";
  endfunction

  always @(negedge clk) begin
    if (rst_n && (out_valid || err_npd)) begin
      int ty;
      ty = err_npd ? 2 : (out_is_y ? 1 : 0);
      checks++;
      if (eidx >= en) begin
        fails++;
        $display("FAIL R7 %s unexpected word row %0d col %0d ty %0d, expected none", scen, out_row, out_col, ty);
      end else begin
        if (ty != et[eidx] ||
            (ty != 2 && (int'(out_row) != er[eidx] || int'(out_col) != ec[eidx] ||
                         longint'($signed(out_val)) != ev[eidx] || out_last != el[eidx]))) begin
          fails++;
          $display("FAIL %s %s actual ty %0d r %0d c %0d v %0d last %0b expected ty %0d r %0d c %0d v %0d last %0b",
                   tag(et[eidx], er[eidx], ec[eidx]), scen, ty, out_row, out_col,
                   longint'($signed(out_val)), out_last, et[eidx], er[eidx], ec[eidx], ev[eidx], el[eidx]);
        end
        eidx++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog expired, actual cycles %0d expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // R10: slots with negative column carry junk that must be ignored
  task automatic send_row(int j, bit last);
    for (int k = 0; k <= W; k++) begin
      int c;
      c = j - W + k;
      in_a[k*DW +: DW] = (c < 0) ? DW'(24'h5A5A5A + k) : DW'(A[j][c]);
    end
    in_b = DW'(bv[j]);
    in_last = last;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (in_ready !== 1'b0) begin
      fails++;
      $display("FAIL R2 in_ready after accept actual %0b expected 0", in_ready);
    end
  endtask

  task automatic run(int n, int nsend);
    int to;
    build(n);
    for (int j = 0; j < nsend; j++) send_row(j, j == n - 1);
    to = 0;
    while (eidx < en && to < 5000) begin @(negedge clk); to++; end
    repeat (5) @(negedge clk);
    checks++;
    if (eidx != en || !in_ready) begin
      fails++;
      $display("FAIL R7 %s words seen %0d expected %0d", scen, eidx, en);
    end
  endtask

  task automatic clear_mat();
    for (int i = 0; i < NMAX; i++) begin
      bv[i] = 0;
      for (int k = 0; k < NMAX; k++) A[i][k] = 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks += 3;
    if (in_ready !== 1'b1) begin fails++; $display("FAIL R1 in_ready actual %0b expected 1", in_ready); end
    if (out_valid !== 1'b0) begin fails++; $display("FAIL R1 out_valid actual %0b expected 0", out_valid); end
    if (err_npd !== 1'b0) begin fails++; $display("FAIL R1 err_npd actual %0b expected 0", err_npd); end

    // single-row sweep of the diagonal, including zero (R9) and small roots (R5)
    scen = "sweep";
    for (int d = 0; d <= 20; d++) begin
      clear_mat();
      A[0][0] = d * ONE / 2;
      bv[0] = (d - 10) * ONE;
      run(1, 1);
    end

    // banded, regular coefficients, junk in unused slots (R10)
    scen = "R10 band";
    clear_mat();
    for (int i = 0; i < 6; i++) begin
      A[i][i] = 5 * ONE;
      if (i >= 1) A[i][i-1] = -ONE;
      if (i >= 2) A[i][i-2] = ONE / 2;
      bv[i] = (i + 1) * ONE;
    end
    run(6, 6);

    // irregular coefficients and signs
    scen = "mixed";
    clear_mat();
    for (int i = 0; i < 7; i++) begin
      A[i][i] = 6 * ONE + i * 307;
      for (int k = 1; k <= W; k++)
        if (i - k >= 0) A[i][i-k] = (((i * 7 + k * 3) % 9) - 4) * ONE / 4;
      bv[i] = (((i * 5) % 11) - 5) * ONE / 2;
    end
    run(7, 7);

    // not positive definite at row 1 (R9)
    scen = "npd";
    clear_mat();
    A[0][0] = ONE; A[1][0] = 2 * ONE; A[1][1] = ONE; A[2][2] = ONE;
    bv[0] = ONE;
    run(3, 2);

    // restart at row 0 after an abort (R9) and after a last row (R8)
    scen = "restart";
    clear_mat();
    for (int i = 0; i < 4; i++) begin
      A[i][i] = 3 * ONE;
      if (i >= 1) A[i][i-1] = ONE / 2;
      bv[i] = ONE - i * 200;
    end
    run(4, 4);
    run(4, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule